// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small table of VLAN entries. Each entry holds a 12-bit VLAN identifier, a 10-bit port membership mask and a valid bit. Software reaches the block over a simple 32-bit register bus that has two words: a command word and a data word. To run a command, software writes the command word with an opcode, a VID and, where needed, a port number, and sets the active bit in the same write. The engine carries the command out over the table and clears the active bit when it is done. Software polls that bit before it issues the next command.

The commands are load, purge, remove-port and flush. Load inserts or updates an entry from the data word. Purge invalidates the entry that matches the VID. Remove-port takes one port out of every entry. Flush clears the whole table one entry per clock. A load that finds neither a matching entry nor a free one raises the full bit.

A separate lookup port runs independently of the bus. It returns, combinationally, the member mask of the valid entry whose VID matches the input.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset both bus words read 0 (active bit 3 and full bit 4 clear), and every lookup misses.
- R2: The command word reads back as op [2:0], active [3], full [4], port [11:8], VID [27:16], priority [30:28] and priority enable [31], with all other bits 0. The data word (byte address 4) reads back as mask [9:0] and valid [11], with all other bits 0. The command word sits at byte address 0.
- R3: Writing the command word with bit 3 set starts the command. Every opcode except flush clears bit 3 one clock after the write is accepted. Flush keeps bit 3 set for as many clocks as the table has entries.
- R4: A command word write while bit 3 is set is ignored: the stored op and VID do not change.
- R5: A load (op 2) of a VID not in the table, with data valid bit 11 set, stores that VID and mask in the lowest free entry. After that, a lookup of the VID hits and returns the mask.
- R6: A load of a VID that is already in the table overwrites the mask of that entry and uses no further entry.
- R7: A load has no effect on the table when data bit 11 is clear or when the VID is 4095. A lookup of VID 4095 never hits.
- R8: A load of a new VID when all entries are in use leaves the table unchanged and sets full bit 4. Accepting the next command word write clears the full bit.
- R9: A purge (op 3) invalidates the entry that matches the VID, and a later load can use the freed entry.
- R10: A remove-port (op 4) clears the bit for port [11:8] in every entry's mask. The entries stay valid, even when their mask becomes empty. A port number of 10 or more changes nothing.
- R11: A flush (op 1) invalidates every entry.
- R12: A lookup that matches no valid entry returns a hit of 0 and a mask of 0.
- R13: Opcodes 0, 5, 6 and 7 complete without changing the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address (0 = command word, 4 = data word) |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| lkVid | input | 12 | VID to look up |
| lkHit | output | 1 | Lookup matched a valid entry |
| lkMask | output | 10 | Member mask of the matching entry, or 0 |

## Verification
The hardest state to reach from the ports is a table with every entry in use, which the full bit and the overwrite-versus-insert choice depend on. The bench fills the table with distinct VIDs and rewrites one of them before loading the last entry. This proves an overwrite uses no entry, because the last load still fits and the load after it is rejected. A second hard case is a command write during a flush: the write is placed inside the multi-cycle flush window, and the bench checks the active bit at the exact final cycle. After every command, all 4096 VIDs are swept on the lookup port and compared against a model.

// File: rtl/vlan_cmd_pkg.sv
package vlan_cmd_pkg;
  localparam int VID_W    = 12;
  localparam int MASK_W   = 10;
  localparam int PORT_W   = 4;
  localparam int PRIO_W   = 3;
  localparam int CMD_OFS  = 0;
  localparam int DATA_OFS = 4;
  localparam logic [VID_W-1:0] VID_RESERVED = '1;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_FLUSH = 3'd1,
    OP_LOAD  = 3'd2,
    OP_PURGE = 3'd3,
    OP_DROP  = 3'd4
  } vtOp_e;

  typedef struct packed {
    logic flushStep;
    logic load;
    logic purge;
    logic dropPort;
  } vtStrobe_t;
endpackage

// File: rtl/vlan_cmd_ctrl.sv
module vlan_cmd_ctrl
  import vlan_cmd_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic              dataWr,
  input  logic [31:0]       wrData,
  input  logic              loadRejected,
  output vtStrobe_t         stb,
  output logic [IDX_W-1:0]  flushIdx,
  output logic [2:0]        cmdOp,
  output logic [PORT_W-1:0] cmdPort,
  output logic [VID_W-1:0]  cmdVid,
  output logic [PRIO_W-1:0] cmdPrio,
  output logic              cmdPrioEn,
  output logic              cmdActive,
  output logic              cmdFull,
  output logic [MASK_W-1:0] dataMask,
  output logic              dataValid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[15:12], wrData[7:4], wrData[10]};

  always_comb begin
    stb.flushStep = cmdActive && (cmdOp == OP_FLUSH);
    stb.load      = cmdActive && (cmdOp == OP_LOAD) && dataValid && (cmdVid != VID_RESERVED);
    stb.purge     = cmdActive && (cmdOp == OP_PURGE);
    stb.dropPort  = cmdActive && (cmdOp == OP_DROP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOp     <= '0;
      cmdPort   <= '0;
      cmdVid    <= '0;
      cmdPrio   <= '0;
      cmdPrioEn <= 1'b0;
      cmdActive <= 1'b0;
      cmdFull   <= 1'b0;
      flushIdx  <= '0;
      dataMask  <= '0;
      dataValid <= 1'b0;
    end else begin
      if (cmdWr && !cmdActive) begin
        cmdOp     <= wrData[2:0];
        cmdActive <= wrData[3];
        cmdPort   <= wrData[11:8];
        cmdVid    <= wrData[27:16];
        cmdPrio   <= wrData[30:28];
        cmdPrioEn <= wrData[31];
        cmdFull   <= 1'b0;
        flushIdx  <= '0;
      end else if (cmdActive) begin
        if (stb.flushStep) begin
          flushIdx <= flushIdx + 1'b1;
          if (flushIdx == LAST_IDX) cmdActive <= 1'b0;
        end else begin
          cmdActive <= 1'b0;
          if (stb.load && loadRejected) cmdFull <= 1'b1;
        end
      end
      if (dataWr) begin
        dataMask  <= wrData[MASK_W-1:0];
        dataValid <= wrData[11];
      end
    end
  end
endmodule

// File: rtl/vlan_cmd_store.sv
module vlan_cmd_store
  import vlan_cmd_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  vtStrobe_t         stb,
  input  logic [IDX_W-1:0]  flushIdx,
  input  logic [VID_W-1:0]  cmdVid,
  input  logic [PORT_W-1:0] cmdPort,
  input  logic [MASK_W-1:0] loadMask,
  output logic              loadRejected,
  input  logic [VID_W-1:0]  lkVid,
  output logic              lkHit,
  output logic [MASK_W-1:0] lkMask
);
  logic [VID_W-1:0]  entVid   [ENTRIES];
  logic [MASK_W-1:0] entMask  [ENTRIES];
  logic [ENTRIES-1:0] entValid;

  logic             matchHit, freeHit;
  logic [IDX_W-1:0] matchIdx, freeIdx;
  logic [MASK_W-1:0] portBit;

  assign portBit = {{(MASK_W-1){1'b0}}, 1'b1} << cmdPort;

  always_comb begin
    matchHit = 1'b0;
    matchIdx = '0;
    freeHit  = 1'b0;
    freeIdx  = '0;
    lkHit    = 1'b0;
    lkMask   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (entValid[i] && entVid[i] == cmdVid) begin
        matchHit = 1'b1;
        matchIdx = IDX_W'(i);
      end
      if (!entValid[i]) begin
        freeHit = 1'b1;
        freeIdx = IDX_W'(i);
      end
      if (entValid[i] && entVid[i] == lkVid) begin
        lkHit  = 1'b1;
        lkMask = entMask[i];
      end
    end
  end

  assign loadRejected = !matchHit && !freeHit;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entVid[i]   <= '0;
        entMask[i]  <= '0;
      end else if (stb.flushStep && flushIdx == IDX_W'(i)) begin
        entValid[i] <= 1'b0;
      end else if (stb.purge && matchHit && matchIdx == IDX_W'(i)) begin
        entValid[i] <= 1'b0;
      end else if (stb.load && ((matchHit && matchIdx == IDX_W'(i)) ||
                                (!matchHit && freeHit && freeIdx == IDX_W'(i)))) begin
        entValid[i] <= 1'b1;
        entVid[i]   <= cmdVid;
        entMask[i]  <= loadMask;
      end else if (stb.dropPort) begin
        entMask[i] <= entMask[i] & ~portBit;
      end
    end
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vlan_cmd_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic [VID_W-1:0]  lkVid,
  output logic              lkHit,
  output logic [MASK_W-1:0] lkMask
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  vtStrobe_t         stb;
  logic [IDX_W-1:0]  flushIdx;
  logic [2:0]        cmdOp;
  logic [PORT_W-1:0] cmdPort;
  logic [VID_W-1:0]  cmdVid;
  logic [PRIO_W-1:0] cmdPrio;
  logic              cmdPrioEn, cmdActive, cmdFull, dataValid, loadRejected;
  logic [MASK_W-1:0] dataMask;
  logic              selCmd, selData;

  assign selCmd  = (busAddr == ADDR_W'(CMD_OFS));
  assign selData = (busAddr == ADDR_W'(DATA_OFS));

  vlan_cmd_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdWr(busWrEn && selCmd), .dataWr(busWrEn && selData),
    .wrData(busWrData), .loadRejected(loadRejected),
    .stb(stb), .flushIdx(flushIdx),
    .cmdOp(cmdOp), .cmdPort(cmdPort), .cmdVid(cmdVid),
    .cmdPrio(cmdPrio), .cmdPrioEn(cmdPrioEn),
    .cmdActive(cmdActive), .cmdFull(cmdFull),
    .dataMask(dataMask), .dataValid(dataValid)
  );

  vlan_cmd_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .flushIdx(flushIdx),
    .cmdVid(cmdVid), .cmdPort(cmdPort), .loadMask(dataMask),
    .loadRejected(loadRejected),
    .lkVid(lkVid), .lkHit(lkHit), .lkMask(lkMask)
  );

  always_comb begin
    busRdData = '0;
    if (selCmd)
      busRdData = {cmdPrioEn, cmdPrio, cmdVid, 4'b0, cmdPort, 3'b0, cmdFull, cmdActive, cmdOp};
    else if (selData)
      busRdData = {20'b0, dataValid, 1'b0, dataMask};
  end
endmodule

// File: rtl/vlan_cmd_checker.sv
module vlan_cmd_checker
  import vlan_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [VID_W-1:0]  lkVid,
  input logic              lkHit,
  input logic [MASK_W-1:0] lkMask,
  input logic [2:0]        cmdOp,
  input logic [VID_W-1:0]  cmdVid,
  input logic              cmdActive,
  input logic              cmdFull
);
  logic cmdWrite;
  assign cmdWrite = busWrEn && (busAddr == ADDR_W'(CMD_OFS));

  AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdActive && cmdWrite) |=> ($stable(cmdVid) && $stable(cmdOp))); // R4

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmdActive && cmdOp != OP_FLUSH) |=> !cmdActive); // R3

  AST_FULL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdFull) |-> $past(cmdActive && cmdOp == OP_LOAD)); // R8

  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cmdFull && cmdWrite && !cmdActive) |=> !cmdFull); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkMask == '0)); // R12

  AST_RESERVED_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (lkVid == VID_RESERVED) |-> !lkHit); // R7
endmodule

bind vlan_cmd_engine vlan_cmd_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .lkVid(lkVid), .lkHit(lkHit), .lkMask(lkMask),
  .cmdOp(cmdOp), .cmdVid(cmdVid), .cmdActive(cmdActive), .cmdFull(cmdFull)
);

// File: tb/test_vlan_cmd_engine.sv
module test_vlan_cmd_engine;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [11:0] lkVid = '0;
  logic        lkHit;
  logic [9:0]  lkMask;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int       mVid   [N];
  bit [9:0] mMask  [N];
  bit       mValid [N];

  always #10 clk = ~clk;

  vlan_cmd_engine #(.ENTRIES(N), .ADDR_W(4)) i_vlan_cmd_engine (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .lkVid(lkVid), .lkHit(lkHit), .lkMask(lkMask)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  function automatic logic [31:0] mkCmd(input int op, input int vid, input int port, input bit act);
    logic [31:0] w;
    w = '0;
    w[2:0] = op[2:0];
    w[3] = act;
    w[11:8] = port[3:0];
    w[27:16] = vid[11:0];
    return w;
  endfunction

  task automatic waitIdle();
    logic [31:0] d;
    for (int k = 0; k < 100; k++) begin
      busRead(4'h0, d);
      if (d[3] == 1'b0) break;
      @(negedge clk);
    end
  endtask

  task automatic runCmd(input int op, input int vid, input int port);
    busWrite(4'h0, mkCmd(op, vid, port, 1'b1));
    waitIdle();
  endtask

  task automatic setData(input logic [9:0] mask, input bit valid);
    busWrite(4'h4, {20'b0, valid, 1'b0, mask});
  endtask

  function automatic bit modelLoad(input int vid, input logic [9:0] mask, input bit valid);
    if (!valid || vid == 4095) return 1'b0;
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVid[i] == vid) begin mMask[i] = mask; return 1'b0; end
    for (int i = 0; i < N; i++)
      if (!mValid[i]) begin mValid[i] = 1; mVid[i] = vid; mMask[i] = mask; return 1'b0; end
    return 1'b1;
  endfunction

  task automatic sweep(input string tag);
    int errs;
    logic expHit;
    logic [9:0] expMask;
    logic gotHit;
    logic [9:0] gotMask;
    int firstV;
    errs = 0;
    firstV = -1;
    gotHit = 0; gotMask = '0; expHit = 0; expMask = '0;
    for (int v = 0; v < 4096; v++) begin
      logic eh;
      logic [9:0] em;
      lkVid = v[11:0];
      #1;
      eh = 0; em = '0;
      for (int i = 0; i < N; i++)
        if (mValid[i] && mVid[i] == v) begin eh = 1; em = mMask[i]; end
      if (lkHit !== eh || lkMask !== em) begin
        if (errs == 0) begin firstV = v; gotHit = lkHit; gotMask = lkMask; expHit = eh; expMask = em; end
        errs++;
      end
    end
    total++;
    if (errs != 0) begin
      bad++;
      $display("FAIL %s lookup vid=%0d actual hit=%b mask=%h expected hit=%b mask=%h (%0d vids wrong)",
               tag, firstV, gotHit, gotMask, expHit, expMask, errs);
    end
    @(negedge clk);
  endtask

  function automatic int vidOf(input int i);
    return i * 257 + 3;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit rej;
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mVid[i] = 0; mMask[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    busRead(4'h0, d); check("R1 command word", d, 32'h0);
    busRead(4'h4, d); check("R1 data word", d, 32'h0);
    sweep("R1 empty table");

    // R2: field layout readback
    busWrite(4'h4, 32'hFFFF_FFFF);
    busRead(4'h4, d); check("R2 data layout", d, 32'h0000_0BFF);
    busWrite(4'h0, 32'hFFFF_FFF7);
    busRead(4'h0, d); check("R2 command layout", d, 32'hFFFF_0F07);

    // R3: one-cycle completion of a plain command
    busWrite(4'h0, mkCmd(0, 0, 0, 1'b1));
    busRead(4'h0, d); check("R3 active after start", {31'b0, d[3]}, 32'h1);
    @(negedge clk);
    busRead(4'h0, d); check("R3 active cleared", {31'b0, d[3]}, 32'h0);

    // R7: ignored loads
    setData(10'h3FF, 1'b0);
    runCmd(2, 100, 0);
    rej = modelLoad(100, 10'h3FF, 1'b0);
    setData(10'h2AA, 1'b1);
    runCmd(2, 4095, 0);
    rej = modelLoad(4095, 10'h2AA, 1'b1);
    lkVid = 12'd4095; #1;
    check("R7 reserved vid miss", {31'b0, lkHit}, 32'h0);
    sweep("R7 table unchanged");

    // R5: fill all but one entry
    for (int i = 0; i < N - 1; i++) begin
      logic [9:0] m;
      m = 10'((i * 37 + 1) & 10'h3FF);
      setData(m, 1'b1);
      runCmd(2, vidOf(i), 0);
      rej = modelLoad(vidOf(i), m, 1'b1);
    end
    sweep("R5 loads");

    // R6: overwrite uses no entry
    setData(10'h004, 1'b1);
    runCmd(2, vidOf(5), 0);
    rej = modelLoad(vidOf(5), 10'h004, 1'b1);
    setData(10'h0F0, 1'b1);
    runCmd(2, vidOf(N - 1), 0);
    rej = modelLoad(vidOf(N - 1), 10'h0F0, 1'b1);
    busRead(4'h0, d); check("R6 last entry fits, full clear", {31'b0, d[4]}, 32'h0);
    sweep("R6 overwrite");

    // R8: full
    setData(10'h111, 1'b1);
    runCmd(2, 4000, 0);
    rej = modelLoad(4000, 10'h111, 1'b1);
    busRead(4'h0, d); check("R8 full set", {31'b0, d[4]}, {31'b0, rej});
    sweep("R8 table unchanged when full");
    runCmd(0, 0, 0);
    busRead(4'h0, d); check("R8 full cleared by next command", {31'b0, d[4]}, 32'h0);

    // R9: purge and reuse
    runCmd(3, vidOf(3), 0);
    mValid[3] = 0;
    sweep("R9 purge");
    setData(10'h155, 1'b1);
    runCmd(2, 4000, 0);
    rej = modelLoad(4000, 10'h155, 1'b1);
    busRead(4'h0, d); check("R9 freed entry reused", {31'b0, d[4]}, 32'h0);
    lkVid = 12'd4000; #1;
    check("R9 reused entry lookup", {21'b0, lkHit, lkMask}, {21'b0, 1'b1, 10'h155});

    // R10: remove port
    runCmd(4, 0, 2);
    for (int i = 0; i < N; i++) mMask[i][2] = 1'b0;
    lkVid = 12'(vidOf(5)); #1;
    check("R10 empty mask stays valid", {21'b0, lkHit, lkMask}, {21'b0, 1'b1, 10'h000});
    sweep("R10 port 2 removed");
    runCmd(4, 0, 12);
    sweep("R10 port 12 no effect");

    // R13: no-op opcodes
    runCmd(5, vidOf(1), 1);
    runCmd(6, vidOf(2), 0);
    runCmd(7, vidOf(4), 3);
    runCmd(0, vidOf(6), 0);
    sweep("R13 no-op opcodes");

    // R11 / R3 / R4: flush timing and locked writes
    busWrite(4'h0, mkCmd(1, 321, 0, 1'b1));
    busWrite(4'h0, mkCmd(2, 77, 5, 1'b1));
    repeat (N - 2) @(negedge clk);
    busRead(4'h0, d); check("R3 flush still active", {31'b0, d[3]}, 32'h1);
    @(negedge clk);
    busRead(4'h0, d); check("R3 flush done", {31'b0, d[3]}, 32'h0);
    check("R4 write during active ignored", {29'b0, d[2:0]}, 32'h1);
    check("R4 vid kept", {20'b0, d[27:16]}, 32'd321);
    for (int i = 0; i < N; i++) mValid[i] = 0;
    sweep("R11 flush");
    lkVid = 12'd3; #1;
    check("R12 miss returns zero", {21'b0, lkHit, lkMask}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule